// File: doc/BRIEF.md
# Outphasing Phase Pair Generator

This block turns a stream of complex baseband samples, already raised to the processing rate (for example 4x, from 50 MHz to 200 MHz), into two phase streams of constant envelope. A vectoring CORDIC finds each sample's magnitude and phase. The magnitude is scaled against a peak value fixed at build time. A table of arccosine values then gives the outphasing angle. The block emits the signal phase minus that angle on one port and the phase plus that angle on the other. Downstream stages use the two phases to drive a pair of switching branches, and the branch sum rebuilds the original amplitude.

All phases are unsigned binary angles: 2^W counts make one full turn, so sums and differences wrap modulo 2π without extra logic. Samples flow through a fixed-latency pipeline under valid/ready handshakes. When the output is held, the whole pipeline stalls as one.

Top module: `outphase_pair_gen`

## Requirements
- R1: Both output phases are W-bit binary angles (2^W = 2π). out_ph_minus = phase − angle and out_ph_plus = phase + angle, so (out_ph_plus − out_ph_minus) mod 2^W is even and at most 2^(W−1).
- R2: The recovered phase (out_ph_minus + spread/2 mod 2^W) matches atan2(in_q, in_i) in binary angle units within 16 counts, in all four quadrants and on the axes.
- R3: The angle (spread/2) equals arccos(min(|in|/PEAK, 1)) in binary angle units. The table holds 2^LW+1 entries, indexed by floor(|in|·2^LW/PEAK), so the angle lies inside the arccos range of ratios within 0.008 of the true ratio, with 4 counts of slack.
- R4: A sample whose magnitude exceeds PEAK saturates to ratio 1: angle 0, so the two outputs are equal.
- R5: A zero sample gives ratio 0 and an angle of a quarter turn, so the spread is exactly 2^(W−1).
- R6: Latency is fixed at LATENCY = ITER+4 register stages. With out_ready held high, a sample accepted on one rising edge appears on the outputs after the LATENCY-th rising edge, counting the accepting edge. One sample is accepted per cycle.
- R7: While out_valid is high and out_ready low, the outputs and out_valid hold. in_ready is high whenever out_valid is low. No sample is lost, duplicated or reordered under stalls.
- R8: Synchronous active-high reset clears out_valid and every sample in flight. in_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts a sample on this cycle |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| out_valid | output | 1 | Output phase pair present |
| out_ready | input | 1 | Consumer takes the pair |
| out_ph_minus | output | W | Phase minus outphasing angle, binary angle |
| out_ph_plus | output | W | Phase plus outphasing angle, binary angle |

## Verification
The bench aims at the ends of the arccosine range. An all-zero sample must give a spread of exactly half a turn; a design with an off-by-one table index or a table built in the wrong direction gives a smaller spread. Samples above the peak, including the most negative corner, must collapse the spread to zero; a design without saturation reads past the table or wraps to a large angle. Samples on the negative in-phase axis and in the second and third quadrants expose a wrong quadrant fold as a half-turn phase error, and a swap of the two outputs shows up as a spread above half a turn. A second pass with an irregular ready pattern catches a pipeline that loses, repeats or reorders samples, or that lets the outputs drift while stalled.

// File: rtl/oppg_pkg.sv
`timescale 1ns/1ps
package oppg_pkg;
  localparam real PI = 3.14159265358979323846;

  // Product of the per-iteration CORDIC stretch factors.
  function automatic real cordic_gain(input int iters);
    real g;
    g = 1.0;
    for (int i = 0; i < iters; i++) g = g * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    return g;
  endfunction

  // Radians to binary angle counts (2^w per turn), rounded.
  function automatic longint bam_of_rad(input real rad, input int w);
    return longint'(rad * (2.0 ** w) / (2.0 * PI));
  endfunction
endpackage

// File: rtl/oppg_cordic.sv
`timescale 1ns/1ps
module oppg_cordic #(
  parameter int DW   = 16,
  parameter int W    = 16,
  parameter int ITER = 16,
  parameter int XW   = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_vld,
  output logic [XW-1:0]        out_mag,
  output logic [W-1:0]         out_phase
);
  logic signed [XW-1:0] xs [0:ITER];
  logic signed [XW-1:0] ys [0:ITER];
  logic [W-1:0]         zs [0:ITER];
  logic                 vs [0:ITER];
  logic [W-1:0]         atan_tab [0:ITER-1];

  for (genvar g = 0; g < ITER; g++) begin : g_atan
    localparam logic [W-1:0] STEP =
      W'(oppg_pkg::bam_of_rad($atan(2.0 ** (-g)), W));
    assign atan_tab[g] = STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= ITER; i++) vs[i] <= 1'b0;
    end else if (en) begin
      vs[0] <= in_vld;
      for (int i = 1; i <= ITER; i++) vs[i] <= vs[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      // fold the left half plane onto the right by a half-turn rotation
      if (in_i < 0) begin
        xs[0] <= -XW'(in_i);
        ys[0] <= -XW'(in_q);
        zs[0] <= W'(1) << (W - 1);
      end else begin
        xs[0] <= XW'(in_i);
        ys[0] <= XW'(in_q);
        zs[0] <= '0;
      end
      for (int i = 0; i < ITER; i++) begin
        if (!ys[i][XW-1]) begin
          xs[i+1] <= xs[i] + (ys[i] >>> i);
          ys[i+1] <= ys[i] - (xs[i] >>> i);
          zs[i+1] <= zs[i] + atan_tab[i];
        end else begin
          xs[i+1] <= xs[i] - (ys[i] >>> i);
          ys[i+1] <= ys[i] + (xs[i] >>> i);
          zs[i+1] <= zs[i] - atan_tab[i];
        end
      end
    end
  end

  assign out_vld   = vs[ITER];
  assign out_mag   = xs[ITER];
  assign out_phase = zs[ITER];
endmodule

// File: rtl/oppg_norm.sv
`timescale 1ns/1ps
module oppg_norm #(
  parameter int XW    = 18,
  parameter int W     = 16,
  parameter int LW    = 8,
  parameter int ITER  = 16,
  parameter int PEAK  = 30000,
  parameter int SH    = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          in_vld,
  input  logic [XW-1:0] in_mag,
  input  logic [W-1:0]  in_phase,
  output logic          out_vld,
  output logic [LW:0]   out_idx,
  output logic [W-1:0]  out_phase
);
  // one constant multiply removes the CORDIC stretch and divides by the peak
  localparam longint K  =
    longint'((2.0 ** (LW + SH)) / (real'(PEAK) * oppg_pkg::cordic_gain(ITER)));
  localparam int KW = $clog2(K + 1);
  localparam int PW = XW + KW;
  localparam int QW = PW - SH;
  localparam logic [QW-1:0] FULL = QW'(1) << LW;

  logic [PW-1:0] prod;
  logic [QW-1:0] ratio;
  logic [LW:0]   idx_c;

  assign prod  = PW'(in_mag) * PW'(K);
  assign ratio = prod[PW-1:SH];
  assign idx_c = (ratio >= FULL) ? FULL[LW:0] : ratio[LW:0];

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else if (en) out_vld <= in_vld;
    if (en) begin
      out_idx   <= idx_c;
      out_phase <= in_phase;
    end
  end
endmodule

// File: rtl/oppg_acos_rom.sv
`timescale 1ns/1ps
module oppg_acos_rom #(
  parameter int LW = 8,
  parameter int W  = 16
) (
  input  logic         clk,
  input  logic         en,
  input  logic [LW:0]  idx,
  output logic [W-1:0] ang
);
  localparam int DEPTH = (1 << LW) + 1;

  logic [W-1:0] rom [0:DEPTH-1];

  initial begin
    for (int k = 0; k < DEPTH; k++)
      rom[k] = W'(oppg_pkg::bam_of_rad($acos(real'(k) / real'(1 << LW)), W));
  end

  always_ff @(posedge clk) begin
    if (en) ang <= rom[idx];
  end
endmodule

// File: rtl/outphase_pair_gen.sv
`timescale 1ns/1ps
module outphase_pair_gen #(
  parameter int DW      = 16,
  parameter int W       = 16,
  parameter int ITER    = 16,
  parameter int LW      = 8,
  parameter int PEAK    = 30000,
  parameter int NORM_SH = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_ph_minus,
  output logic [W-1:0]         out_ph_plus
);
  localparam int XW      = DW + 2;
  localparam int LATENCY = ITER + 4;

  logic          adv;
  logic          c_vld, n_vld, r_vld;
  logic [XW-1:0] c_mag;
  logic [W-1:0]  c_phase, n_phase, r_phase, r_ang;
  logic [LW:0]   n_idx;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  oppg_cordic #(.DW(DW), .W(W), .ITER(ITER), .XW(XW)) u_cordic (
    .clk(clk), .rst(rst), .en(adv),
    .in_vld(in_valid && adv), .in_i(in_i), .in_q(in_q),
    .out_vld(c_vld), .out_mag(c_mag), .out_phase(c_phase)
  );

  oppg_norm #(.XW(XW), .W(W), .LW(LW), .ITER(ITER), .PEAK(PEAK), .SH(NORM_SH)) u_norm (
    .clk(clk), .rst(rst), .en(adv),
    .in_vld(c_vld), .in_mag(c_mag), .in_phase(c_phase),
    .out_vld(n_vld), .out_idx(n_idx), .out_phase(n_phase)
  );

  oppg_acos_rom #(.LW(LW), .W(W)) u_rom (
    .clk(clk), .en(adv), .idx(n_idx), .ang(r_ang)
  );

  always_ff @(posedge clk) begin
    if (rst) r_vld <= 1'b0;
    else if (adv) r_vld <= n_vld;
    if (adv) r_phase <= n_phase;
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (adv) out_valid <= r_vld;
    if (adv) begin
      out_ph_minus <= r_phase - r_ang;
      out_ph_plus  <= r_phase + r_ang;
    end
  end
endmodule

// File: rtl/outphase_pair_gen_chk.sv
`timescale 1ns/1ps
module outphase_pair_gen_chk #(
  parameter int W       = 16,
  parameter int LATENCY = 20
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_ph_minus,
  input logic [W-1:0] out_ph_plus
);
  logic [W-1:0] spread;
  int           pending;

  assign spread = out_ph_plus - out_ph_minus;

  always_ff @(posedge clk) begin
    if (rst) pending <= 0;
    else pending <= pending + int'(in_valid && in_ready) - int'(out_valid && out_ready);
  end

  // R1: plus-side leads minus-side by twice a non-negative angle of at most a quarter turn
  a_r1_even_spread: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!spread[0] && spread <= (W'(1) << (W - 1))));

  // R6: never more samples in flight than pipeline stages
  a_r6_bounded_flight: assert property (@(posedge clk) disable iff (rst)
    pending >= 0 && pending <= LATENCY);

  // R7: held outputs do not move
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ph_minus) && $stable(out_ph_plus)));

  // R7: an empty output register never blocks the input
  a_r7_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R8: the cycle after reset shows no output
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

bind outphase_pair_gen outphase_pair_gen_chk #(.W(W), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_ph_minus(out_ph_minus), .out_ph_plus(out_ph_plus)
);

// File: tb/outphase_pair_gen_tb.sv
`timescale 1ns/1ps
module outphase_pair_gen_tb;
  localparam int  LAT  = 20;          // ITER + 4 with ITER = 16
  localparam int  NV   = 14;
  localparam real PEAK = 30000.0;
  localparam real PI   = 3.14159265358979323846;

  // stimulus table: I, Q, kind (0 general, 1 saturated R4, 2 zero R5)
  localparam logic signed [15:0] VI [NV] = '{
    16'sd20000, 16'sd0, -16'sd20000, 16'sd0, 16'sd15000, -16'sd12000, -16'sd5000,
    16'sd24000, 16'sd3000, 16'sd30000, 16'sd32767, 16'sh8000, 16'sd0, 16'sd21213};
  localparam logic signed [15:0] VQ [NV] = '{
    16'sd0, 16'sd20000, 16'sd0, -16'sd20000, 16'sd15000, 16'sd9000, -16'sd21000,
    -16'sd7000, 16'sd4000, 16'sd0, 16'sd0, 16'sh8000, 16'sd0, 16'sd21213};
  localparam int VK [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic in_ready, out_valid;
  logic [15:0] out_ph_minus, out_ph_plus;

  int checks = 0, fails = 0, ncap = 0;
  bit done = 1'b0;
  logic [15:0] cap_m [64];
  logic [15:0] cap_p [64];
  bit held = 1'b0;
  logic [15:0] held_m, held_p;

  always #2 clk = ~clk;

  outphase_pair_gen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_ph_minus(out_ph_minus), .out_ph_plus(out_ph_plus));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic int wrap16(input int v);
    return ((v % 65536) + 65536) % 65536;
  endfunction

  function automatic int cdist(input int a, input int b);
    int d;
    d = wrap16(a - b);
    return (d > 32768) ? 65536 - d : d;
  endfunction

  function automatic int rad2cnt(input real r);
    return int'(r * 65536.0 / (2.0 * PI));
  endfunction

  // one cycle: drive after the falling edge, sample 1 ns later
  task automatic cyc(input logic iv, input logic signed [15:0] ii,
                     input logic signed [15:0] qq, input logic rdy, output bit acc);
    @(negedge clk);
    in_valid = iv; in_i = ii; in_q = qq; out_ready = rdy;
    #1;
    if (held)
      chk(out_valid && out_ph_minus == held_m && out_ph_plus == held_p,
          "R7", "stalled output held", longint'(out_ph_plus), longint'(held_p));
    held = out_valid && !out_ready;
    held_m = out_ph_minus; held_p = out_ph_plus;
    if (out_valid && out_ready && ncap < 64) begin
      cap_m[ncap] = out_ph_minus; cap_p[ncap] = out_ph_plus; ncap++;
    end
    acc = iv && in_ready;
  endtask

  task automatic check_vec(input int k, input string tag);
    int spread, ang, ph, lo, hi, eph;
    real r;
    spread = wrap16(int'(cap_p[k]) - int'(cap_m[k]));
    ang = spread / 2;
    ph  = wrap16(int'(cap_m[k]) + ang);
    chk(spread % 2 == 0 && spread <= 32768, "R1", {tag, " spread even, at most half turn"},
        spread, 32768);
    if (VK[k] == 2) begin
      chk(spread == 32768, "R5", {tag, " zero sample spread"}, spread, 32768);
    end else if (VK[k] == 1) begin
      chk(spread == 0, "R4", {tag, " saturated sample spread"}, spread, 0);
    end else begin
      r  = $sqrt(real'(VI[k]) * real'(VI[k]) + real'(VQ[k]) * real'(VQ[k])) / PEAK;
      lo = rad2cnt($acos((r + 0.008 > 1.0) ? 1.0 : r + 0.008)) - 4;
      hi = rad2cnt($acos((r - 0.008 < 0.0) ? 0.0 : r - 0.008)) + 4;
      chk(ang >= lo && ang <= hi, "R3", {tag, " outphasing angle"}, ang, (lo + hi) / 2);
      eph = wrap16(rad2cnt($atan2(real'(VQ[k]), real'(VI[k]))));
      chk(cdist(ph, eph) <= 16, "R2", {tag, " signal phase"}, ph, eph);
    end
  endtask

  task automatic run_stream(input bit stall, output int cycles);
    int idx;
    bit acc;
    logic rdy;
    idx = 0; cycles = 0; ncap = 0;
    while (ncap < NV && cycles < 500) begin
      rdy = stall ? ((cycles % 3) != 1) : 1'b1;
      if (idx < NV) cyc(1'b1, VI[idx], VQ[idx], rdy, acc);
      else cyc(1'b0, 16'sd0, 16'sd0, rdy, acc);
      if (acc) idx++;
      cycles++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cycles, k, seen;
    bit acc;
    // R8: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid, "R8", "out_valid after reset", out_valid, 0);
    chk(in_ready, "R8", "in_ready after reset", in_ready, 1);

    // R6: single-sample latency
    cyc(1'b1, 16'sd20000, 16'sd0, 1'b1, acc);
    chk(acc, "R6", "sample accepted on empty pipe", acc, 1);
    k = 0;
    for (int n = 1; n <= LAT + 5; n++) begin
      cyc(1'b0, 16'sd0, 16'sd0, 1'b1, acc);
      if (out_valid && k == 0) k = n;
    end
    chk(k == LAT, "R6", "cycles to first output", k, LAT);

    // table pass, free flow: R1-R5 and R6 throughput
    run_stream(1'b0, cycles);
    chk(cycles == NV + LAT, "R6", "back-to-back stream duration", cycles, NV + LAT);
    chk(ncap == NV, "R6", "outputs collected free flow", ncap, NV);
    for (int v = 0; v < NV; v++) check_vec(v, "free");

    // table pass with irregular backpressure: R7 order and count
    run_stream(1'b1, cycles);
    chk(ncap == NV, "R7", "outputs collected under stall", ncap, NV);
    for (int v = 0; v < NV; v++) check_vec(v, "stall");
    repeat (LAT + 4) cyc(1'b0, 16'sd0, 16'sd0, 1'b1, acc);
    chk(!out_valid, "R7", "no extra output after stream", out_valid, 0);

    // R8: reset in mid-stream drops everything in flight
    for (int n = 0; n < 6; n++) cyc(1'b1, VI[n], VQ[n], 1'b1, acc);
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    seen = 0;
    for (int n = 0; n < LAT + 5; n++) begin
      cyc(1'b0, 16'sd0, 16'sd0, 1'b1, acc);
      if (out_valid) seen++;
    end
    chk(seen == 0, "R8", "outputs after mid-stream reset", seen, 0);

    summary();
  end
endmodule